// File: doc/BRIEF.md
# Chained Transmit Command Queue

This block sits between a processor and the link engine of a token-passing network controller. It accepts transmit commands that name a packet page. It keeps one command waiting behind the command being worked on. When the link reports that the token has arrived, it hands the oldest armed page to the link. When the link reports completion, the block records whether the far node acknowledged.

Results are kept in two slots so that the processor can read them one at a time. The front result drives a done flag and an acknowledge flag, and an interrupt line sits behind a mask input. Only an explicit clear command retires the front result. After a clear, the interrupt line stays low for a fixed number of cycles before a buffered second result can raise it again. A cancel command drops the oldest outstanding entry, even if that entry is already on the wire.

Command codes on `cmd_op`: 2'b00 no operation, 2'b01 enqueue transmit, 2'b10 clear transmit interrupt, 2'b11 cancel oldest.

Top module: `tx_chain_queue`

## Requirements
- R1: After reset, `tx_avail` is 1, and `done_flag`, `ack_flag`, `irq`, `overflow` and `tx_launch` are all 0.
- R2: An enqueue command (`cmd_op`=2'b01) stores `cmd_page` and drops `tx_avail` at the next edge. In a cycle where `token_in` is high, the block is not busy, an entry is present and a result slot is free, `tx_launch` pulses combinationally with `tx_page` equal to the oldest stored page.
- R3: While a transmission is in flight, a token does not launch. Once it completes, the pending entry launches at the next token with its own page.
- R4: A `tx_done` pulse while busy sets `done_flag` and latches `tx_ack` as the result. `irq` is high when `done_flag` is set, `irq_mask` is 1 and no quiet window is running.
- R5: Only the clear command (2'b10) lowers `done_flag`. Tokens, enqueues and idle cycles leave it set.
- R6: A second completion while the first result is unread is held back. The flags keep showing the first result until a clear, and then they show the second one.
- R7: After a clear, `irq` stays 0 for exactly GAP_CYCLES clock edges, then rises if a result is still shown and the mask allows it.
- R8: `irq_mask`=0 forces `irq` to 0 without changing `done_flag`.
- R9: A cancel (2'b11) removes the oldest entry, and two cancels empty the queue. Cancelling an in-flight entry makes its later `tx_done` have no effect on the flags.
- R10: An enqueue while both entries are occupied is dropped, and `overflow` goes to 1 and stays 1 until reset.
- R11: No launch occurs while both result slots hold unread results.
- R12: `ack_flag` is 0 whenever `done_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| cmd_page | input | PAGE_W | Page for enqueue |
| token_in | input | 1 | Token arrival pulse from link |
| tx_done | input | 1 | Transmission completed pulse |
| tx_ack | input | 1 | Far node acknowledged, valid with tx_done |
| irq_mask | input | 1 | Interrupt enable for the done flag |
| tx_launch | output | 1 | Start transmission of tx_page |
| tx_page | output | PAGE_W | Page of the oldest entry |
| tx_avail | output | 1 | Queue empty and nothing in flight |
| done_flag | output | 1 | A completion result is shown |
| ack_flag | output | 1 | Shown result was acknowledged |
| irq | output | 1 | Transmit interrupt |
| overflow | output | 1 | Sticky: an enqueue was dropped |

## Verification
The assertions assume that the link raises `tx_done` only for a page it was handed, that it issues one completion per launch, and that every input is a single-cycle pulse sampled at the rising edge. The bench drives every input on the falling edge, and it pulses `tx_done` only after a launch it has observed. It never puts a cancel and a completion in the same cycle. It holds the mask high except in the one test of masking, so the interrupt checks see only the effects of the done flag and of the quiet window.

// File: rtl/tx_chain_queue.sv
module tx_chain_queue #(
  parameter int PAGE_W     = 8,
  parameter int GAP_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              token_in,
  input  logic              tx_done,
  input  logic              tx_ack,
  input  logic              irq_mask,
  output logic              tx_launch,
  output logic [PAGE_W-1:0] tx_page,
  output logic              tx_avail,
  output logic              done_flag,
  output logic              ack_flag,
  output logic              irq,
  output logic              overflow
);

  localparam int GW = $clog2(GAP_CYCLES + 1);

  logic [1:0]        qv, qv_n;
  logic [PAGE_W-1:0] qp0, qp1, qp0_n, qp1_n;
  logic              busy, busy_n;
  logic [1:0]        rv, ra, rv_n, ra_n;
  logic [GW-1:0]     gap;
  logic              ovf_q, ovf_n;

  wire en_cmd  = cmd_valid && (cmd_op == 2'b01);
  wire clr_cmd = cmd_valid && (cmd_op == 2'b10);
  wire dis_cmd = cmd_valid && (cmd_op == 2'b11);
  wire fin     = tx_done && busy;

  assign tx_launch = token_in && qv[0] && !busy && !rv[1];
  assign tx_page   = qp0;
  assign tx_avail  = !qv[0] && !qv[1] && !busy;
  assign done_flag = rv[0];
  assign ack_flag  = rv[0] && ra[0];
  assign irq       = rv[0] && irq_mask && (gap == '0);
  assign overflow  = ovf_q;

  always_comb begin
    qv_n   = qv;
    qp0_n  = qp0;
    qp1_n  = qp1;
    busy_n = busy || tx_launch;
    ovf_n  = ovf_q;

    if (fin) begin
      qv_n   = {1'b0, qv_n[1]};
      qp0_n  = qp1_n;
      busy_n = 1'b0;
    end

    if (dis_cmd && qv_n[0]) begin
      if (!fin) busy_n = 1'b0;
      qv_n  = {1'b0, qv_n[1]};
      qp0_n = qp1_n;
    end

    if (en_cmd) begin
      if (!qv_n[0]) begin
        qv_n[0] = 1'b1;
        qp0_n   = cmd_page;
      end else if (!qv_n[1]) begin
        qv_n[1] = 1'b1;
        qp1_n   = cmd_page;
      end else begin
        ovf_n = 1'b1;
      end
    end
  end

  always_comb begin
    rv_n = rv;
    ra_n = ra;
    if (clr_cmd) begin
      rv_n = {1'b0, rv[1]};
      ra_n = {1'b0, ra[1]};
    end
    if (fin) begin
      if (!rv_n[0]) begin
        rv_n[0] = 1'b1;
        ra_n[0] = tx_ack;
      end else begin
        rv_n[1] = 1'b1;
        ra_n[1] = tx_ack;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qv    <= '0;
      qp0   <= '0;
      qp1   <= '0;
      busy  <= 1'b0;
      rv    <= '0;
      ra    <= '0;
      gap   <= '0;
      ovf_q <= 1'b0;
    end else begin
      qv    <= qv_n;
      qp0   <= qp0_n;
      qp1   <= qp1_n;
      busy  <= busy_n;
      rv    <= rv_n;
      ra    <= ra_n;
      ovf_q <= ovf_n;
      if (clr_cmd)          gap <= GW'(GAP_CYCLES);
      else if (gap != '0)   gap <= gap - 1'b1;
    end
  end

endmodule

// File: rtl/tx_chain_queue_checker.sv
module tx_chain_queue_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       irq_mask,
  input logic       tx_launch,
  input logic       tx_avail,
  input logic       done_flag,
  input logic       ack_flag,
  input logic       irq,
  input logic       overflow
);

  AST_LAUNCH_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_launch |-> !tx_avail); // R2

  AST_LAUNCH_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_launch |=> !tx_avail); // R3

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag); // R4

  AST_DONE_CLEARED_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> $past(cmd_valid && cmd_op == 2'b10)); // R5

  AST_IRQ_QUIET_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && cmd_op == 2'b10) |-> !irq); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq); // R8

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R10

  AST_ACK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_flag |-> done_flag); // R12

endmodule

bind tx_chain_queue tx_chain_queue_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .irq_mask(irq_mask), .tx_launch(tx_launch), .tx_avail(tx_avail),
  .done_flag(done_flag), .ack_flag(ack_flag), .irq(irq), .overflow(overflow)
);

// File: tb/tx_chain_queue_test.sv
`timescale 1ns/1ps
module tx_chain_queue_test;
  localparam int PAGE_W = 8;
  localparam int GAP    = 50;
  localparam int NV     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [PAGE_W-1:0] cmd_page = '0;
  logic token_in = 1'b0, tx_done = 1'b0, tx_ack = 1'b0, irq_mask = 1'b1;
  logic tx_launch, tx_avail, done_flag, ack_flag, irq, overflow;
  logic [PAGE_W-1:0] tx_page;
  logic seen_launch;
  logic [PAGE_W-1:0] seen_page;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  tx_chain_queue #(.PAGE_W(PAGE_W), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .token_in(token_in), .tx_done(tx_done),
    .tx_ack(tx_ack), .irq_mask(irq_mask), .tx_launch(tx_launch),
    .tx_page(tx_page), .tx_avail(tx_avail), .done_flag(done_flag),
    .ack_flag(ack_flag), .irq(irq), .overflow(overflow));

  // {op[2], page[4], tok, done, ack, exp_launch, exp_page[4], exp_avail, exp_done, exp_ack}
  localparam logic [16:0] VEC [NV] = '{
    {2'd1, 4'd3,  3'b000, 1'b0, 4'd0,  3'b000}, // R2 enqueue first
    {2'd1, 4'd5,  3'b000, 1'b0, 4'd0,  3'b000}, // R2 enqueue second
    {2'd0, 4'd0,  3'b100, 1'b1, 4'd3,  3'b000}, // R2 launch oldest
    {2'd0, 4'd0,  3'b100, 1'b0, 4'd0,  3'b000}, // R3 token while busy
    {2'd0, 4'd0,  3'b011, 1'b0, 4'd0,  3'b011}, // R4 acked completion
    {2'd0, 4'd0,  3'b100, 1'b1, 4'd5,  3'b011}, // R3 chained launch
    {2'd0, 4'd0,  3'b010, 1'b0, 4'd0,  3'b111}, // R6 second result held
    {2'd2, 4'd0,  3'b000, 1'b0, 4'd0,  3'b110}, // R6 second result shown
    {2'd2, 4'd0,  3'b000, 1'b0, 4'd0,  3'b100}, // R12 ack low without done
    {2'd1, 4'd9,  3'b000, 1'b0, 4'd0,  3'b000},
    {2'd1, 4'd10, 3'b000, 1'b0, 4'd0,  3'b000},
    {2'd1, 4'd11, 3'b000, 1'b0, 4'd0,  3'b000}, // R10 dropped
    {2'd3, 4'd0,  3'b000, 1'b0, 4'd0,  3'b000}, // R9 cancel oldest
    {2'd0, 4'd0,  3'b100, 1'b1, 4'd10, 3'b000}, // R9 survivor launches
    {2'd0, 4'd0,  3'b011, 1'b0, 4'd0,  3'b111},
    {2'd2, 4'd0,  3'b000, 1'b0, 4'd0,  3'b100}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] op, input int pg, input logic tok,
                     input logic dn, input logic ak);
    cmd_valid = (op != 2'b00);
    cmd_op    = op;
    cmd_page  = PAGE_W'(pg);
    token_in  = tok;
    tx_done   = dn;
    tx_ack    = ak;
    #1;
    seen_launch = tx_launch;
    seen_page   = tx_page;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; token_in = 1'b0; tx_done = 1'b0; tx_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 tx_avail", tx_avail, 1);
    check("R1 done_flag", done_flag, 0);
    check("R1 ack_flag", ack_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 overflow", overflow, 0);
    check("R1 tx_launch", tx_launch, 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      cyc(v[16:15], int'(v[14:11]), v[10], v[9], v[8]);
      check($sformatf("R2/R3 table %0d launch", i), seen_launch, v[7]);
      if (v[7]) check($sformatf("R2 table %0d page", i), seen_page, v[6:3]);
      check($sformatf("R9 table %0d avail", i), tx_avail, v[2]);
      check($sformatf("R4/R5 table %0d done", i), done_flag, v[1]);
      check($sformatf("R6/R12 table %0d ack", i), ack_flag, v[0]);
    end
    check("R10 overflow sticky", overflow, 1);

    repeat (60) cyc(2'd0, 0, 1'b0, 1'b0, 1'b0);
    cyc(2'd1, 1, 1'b0, 1'b0, 1'b0);
    cyc(2'd1, 2, 1'b0, 1'b0, 1'b0);
    cyc(2'd0, 0, 1'b1, 1'b0, 1'b0);
    check("R2 launch page 1", seen_page, 1);
    cyc(2'd0, 0, 1'b0, 1'b1, 1'b0);
    check("R4 irq after completion", irq, 1);
    cyc(2'd0, 0, 1'b1, 1'b0, 1'b0);
    check("R3 chained page 2", seen_page, 2);
    cyc(2'd0, 0, 1'b0, 1'b1, 1'b1);
    check("R6 first result kept", ack_flag, 0);
    cyc(2'd1, 7, 1'b0, 1'b0, 1'b0);
    cyc(2'd0, 0, 1'b1, 1'b0, 1'b0);
    check("R11 no launch with slots full", seen_launch, 0);
    cyc(2'd2, 0, 1'b0, 1'b0, 1'b0);
    check("R6 second result after clear", ack_flag, 1);
    check("R7 irq low after clear", irq, 0);
    begin
      int n = 0;
      while (!irq && n < 200) begin
        cyc(2'd0, 0, 1'b0, 1'b0, 1'b0);
        n++;
      end
      check("R7 quiet window length", n, GAP);
    end
    irq_mask = 1'b0;
    #1;
    check("R8 irq masked", irq, 0);
    check("R8 done unaffected by mask", done_flag, 1);
    irq_mask = 1'b1;
    cyc(2'd1, 8, 1'b0, 1'b0, 1'b0);
    cyc(2'd0, 0, 1'b0, 1'b0, 1'b0);
    check("R5 done kept by enqueue and idle", done_flag, 1);
    cyc(2'd3, 0, 1'b0, 1'b0, 1'b0);
    check("R9 one cancel leaves entry", tx_avail, 0);
    cyc(2'd3, 0, 1'b0, 1'b0, 1'b0);
    check("R9 two cancels empty queue", tx_avail, 1);
    cyc(2'd2, 0, 1'b0, 1'b0, 1'b0);
    check("R5 clear lowers done", done_flag, 0);
    cyc(2'd1, 4, 1'b0, 1'b0, 1'b0);
    cyc(2'd0, 0, 1'b1, 1'b0, 1'b0);
    check("R9 launch before cancel", seen_launch, 1);
    cyc(2'd3, 0, 1'b0, 1'b0, 1'b0);
    check("R9 in-flight cancel frees", tx_avail, 1);
    cyc(2'd0, 0, 1'b0, 1'b1, 1'b1);
    check("R9 late completion ignored", done_flag, 0);
    check("R12 ack low", ack_flag, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule